// File: doc/BRIEF.md
# Passive JTAG Scan Monitor

This block listens to the four data-path wires of a JTAG port (test clock, mode select, data in and data out) without ever driving any of them. It samples the wires into a faster system clock, finds each rising edge of the test clock, and runs its own copy of the 16-state test access port controller so that it stays in step with the target device. Every edge is announced on a one-cycle strobe that carries the state before the edge; the state after the edge is always visible on the current-state output.

While the tracked controller sits in a shift state, the monitor collects the bit on the data-in wire and the bit on the data-out wire into two accumulators, first bit in the least significant position. When a scan reaches its update state, the monitor emits a one-cycle report holding both words, the number of bits shifted, whether the scan targeted the instruction register or a data register, and an overflow flag for scans longer than the accumulator width. It suits a debug bus sniffer or a trace block that must log traffic on a scan chain.

State codes used on the state outputs: 0 reset, 1 idle, 2 data-select, 3 data-capture, 4 data-shift, 5 data-exit1, 6 data-pause, 7 data-exit2, 8 data-update, 9 instr-select, 10 instr-capture, 11 instr-shift, 12 instr-exit1, 13 instr-pause, 14 instr-exit2, 15 instr-update.

Top module: `jtag_scan_monitor`

## Requirements
- R1: After the synchronous active-high reset, `st_cur` reads 1 (idle), and `st_step` and `rpt_valid` are 0.
- R2: The tracked state changes only on a rising test-clock edge and uses the mode-select value sampled at that edge; mode-select and data activity while the test clock holds still leave `st_cur` unchanged.
- R3: Outside the scan groups, with mode-select 1 / 0: reset (0) goes to 0 / 1; idle (1) goes to 2 / 1; data-select (2) goes to 9 / 3; instr-select (9) goes to 0 / 10.
- R4: Inside each scan group (data codes 3..8, instruction codes 10..15), with mode-select 1 / 0: capture goes to exit1 / shift; shift goes to exit1 / shift; exit1 goes to update / pause; pause goes to exit2 / pause; exit2 goes to update / shift; update goes to data-select (2) / idle (1).
- R5: On every rising test-clock edge `st_step` is high for exactly one system cycle, with `st_prev` holding the code before the edge and `st_cur` the code after it.
- R6: A data-in and a data-out bit are recorded only at edges whose prior state is a shift state (4 or 11); bits seen on edges leaving exit1, pause or exit2 are not part of the word. The first recorded bit is bit 0 of the reported words.
- R7: At each edge whose next state is an update state (8 or 15), `rpt_valid` pulses for one cycle with `rpt_is_ir` = 1 for code 15 and 0 for code 8, `rpt_len` equal to the number of recorded bits, and both accumulators empty for the next scan.
- R8: Bits past the accumulator width `ACC_W` are dropped from the words while `rpt_len` keeps counting; `rpt_ovf` is 1 exactly when `rpt_len` exceeds `ACC_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the test clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Observed test clock |
| tms | input | 1 | Observed mode select |
| tdi | input | 1 | Observed data into the target |
| tdo | input | 1 | Observed data out of the target |
| st_cur | output | 4 | Tracked controller state code |
| st_prev | output | 4 | State code before the latest edge |
| st_step | output | 1 | One-cycle strobe per rising test-clock edge |
| rpt_valid | output | 1 | One-cycle scan report strobe |
| rpt_is_ir | output | 1 | Report is an instruction-register scan |
| rpt_tdi | output | ACC_W | Data-in word, first bit at bit 0 |
| rpt_tdo | output | ACC_W | Data-out word, first bit at bit 0 |
| rpt_len | output | LEN_W | Number of bits shifted in the scan |
| rpt_ovf | output | 1 | Scan was longer than ACC_W |

## Verification
A walk from the reset state to each of the sixteen states followed by one edge with mode-select 0 and one with 1 separates every transition from its neighbour. Scans with distinct data-in and data-out patterns tell the two lanes apart and expose a reversed bit order, while scans broken by a pause and an exit2 show that bits on non-shift edges are left out. An instruction scan next to data scans tells the register type apart, and a 70-bit data scan probes the overflow rule and the length counter beyond the word width.

// File: rtl/jtm_pkg.sv
package jtm_pkg;
  typedef enum logic [3:0] {
    TS_RESET = 4'd0,  TS_IDLE  = 4'd1,
    TS_DSEL  = 4'd2,  TS_DCAP  = 4'd3,  TS_DSHF = 4'd4,  TS_DEX1 = 4'd5,
    TS_DPAU  = 4'd6,  TS_DEX2  = 4'd7,  TS_DUPD = 4'd8,
    TS_ISEL  = 4'd9,  TS_ICAP  = 4'd10, TS_ISHF = 4'd11, TS_IEX1 = 4'd12,
    TS_IPAU  = 4'd13, TS_IEX2  = 4'd14, TS_IUPD = 4'd15
  } tap_st_e;
endpackage

// File: rtl/jtm_sync.sv
module jtm_sync #(
  parameter int LINES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  logic [LINES-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/jtm_tracker.sv
module jtm_tracker
  import jtm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    edge_i,
  input  logic    tms_i,
  output tap_st_e cur_o,
  output tap_st_e nxt_o,
  output tap_st_e prev_o,
  output logic    step_o
);
  always_comb begin
    unique case (cur_o)
      TS_RESET: nxt_o = tms_i ? TS_RESET : TS_IDLE;
      TS_IDLE:  nxt_o = tms_i ? TS_DSEL  : TS_IDLE;
      TS_DSEL:  nxt_o = tms_i ? TS_ISEL  : TS_DCAP;
      TS_ISEL:  nxt_o = tms_i ? TS_RESET : TS_ICAP;
      TS_DCAP, TS_DSHF: nxt_o = tms_i ? TS_DEX1 : TS_DSHF;
      TS_DEX1:  nxt_o = tms_i ? TS_DUPD  : TS_DPAU;
      TS_DPAU:  nxt_o = tms_i ? TS_DEX2  : TS_DPAU;
      TS_DEX2:  nxt_o = tms_i ? TS_DUPD  : TS_DSHF;
      TS_ICAP, TS_ISHF: nxt_o = tms_i ? TS_IEX1 : TS_ISHF;
      TS_IEX1:  nxt_o = tms_i ? TS_IUPD  : TS_IPAU;
      TS_IPAU:  nxt_o = tms_i ? TS_IEX2  : TS_IPAU;
      TS_IEX2:  nxt_o = tms_i ? TS_IUPD  : TS_ISHF;
      default:  nxt_o = tms_i ? TS_DSEL  : TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= TS_IDLE;
      prev_o <= TS_IDLE;
      step_o <= 1'b0;
    end else begin
      step_o <= edge_i;
      if (edge_i) begin
        prev_o <= cur_o;
        cur_o  <= nxt_o;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (cur_o == TS_IDLE && !step_o));
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !edge_i |=> $stable(cur_o));
  a_r3_reset_sticks: assert property (@(posedge clk) disable iff (rst)
    (edge_i && tms_i && cur_o == TS_RESET) |=> cur_o == TS_RESET);
  a_r4_shift_stays: assert property (@(posedge clk) disable iff (rst)
    (edge_i && !tms_i && cur_o == TS_DSHF) |=> cur_o == TS_DSHF);
  a_r5_step_single: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);
endmodule

// File: rtl/jtm_lane.sv
module jtm_lane #(
  parameter int W  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic          bit_i,
  input  logic          cap_i,
  output logic [W-1:0]  word_o
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      word_o <= '0;
    end else begin
      if (cap_i) word_o <= sh;
      if (clr_i)     sh        <= '0;
      else if (wr_i) sh[idx_i] <= bit_i;
    end
  end
endmodule

// File: rtl/jtm_scan_ctl.sv
module jtm_scan_ctl
  import jtm_pkg::*;
#(
  parameter int ACC_W = 64,
  parameter int LEN_W = 16,
  localparam int IW = (ACC_W > 1) ? $clog2(ACC_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  tap_st_e          cur_i,
  input  tap_st_e          nxt_i,
  output logic             wr_o,
  output logic             clr_o,
  output logic             cap_o,
  output logic [IW-1:0]    idx_o,
  output logic             rpt_valid,
  output logic             rpt_is_ir,
  output logic [LEN_W-1:0] rpt_len,
  output logic             rpt_ovf
);
  localparam logic [LEN_W-1:0] WLIM = LEN_W'(ACC_W);

  logic [LEN_W-1:0] cnt;
  logic shift_now, upd_now, capst_now;

  assign shift_now = edge_i && (cur_i == TS_DSHF || cur_i == TS_ISHF);
  assign upd_now   = edge_i && (nxt_i == TS_DUPD || nxt_i == TS_IUPD);
  assign capst_now = edge_i && (nxt_i == TS_DCAP || nxt_i == TS_ICAP);
  assign wr_o      = shift_now && (cnt < WLIM);
  assign clr_o     = upd_now || capst_now;
  assign cap_o     = upd_now;
  assign idx_o     = cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      rpt_valid <= 1'b0;
      rpt_is_ir <= 1'b0;
      rpt_len   <= '0;
      rpt_ovf   <= 1'b0;
    end else begin
      rpt_valid <= upd_now;
      if (upd_now) begin
        rpt_is_ir <= (nxt_i == TS_IUPD);
        rpt_len   <= cnt;
        rpt_ovf   <= (cnt > WLIM);
      end
      if (clr_o) cnt <= '0;
      else if (shift_now && cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> !rpt_valid);
  a_r7_count_cleared: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> cnt == '0);
  a_r8_len_within: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_ovf) |-> rpt_len <= WLIM);
  a_r6_write_only_in_shift: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> (cur_i == TS_DSHF || cur_i == TS_ISHF));
endmodule

// File: rtl/jtag_scan_monitor.sv
module jtag_scan_monitor
  import jtm_pkg::*;
#(
  parameter int ACC_W       = 64,
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IW = (ACC_W > 1) ? $clog2(ACC_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             tdo,
  output logic [3:0]       st_cur,
  output logic [3:0]       st_prev,
  output logic             st_step,
  output logic             rpt_valid,
  output logic             rpt_is_ir,
  output logic [ACC_W-1:0] rpt_tdi,
  output logic [ACC_W-1:0] rpt_tdo,
  output logic [LEN_W-1:0] rpt_len,
  output logic             rpt_ovf
);
  logic [3:0] pins_s;
  logic       tck_d, tck_rise;
  tap_st_e    cur, nxt, prev;
  logic       wr, clr, cap;
  logic [IW-1:0] idx;
  logic [1:0] lane_bit;
  logic [ACC_W-1:0] lane_word [2];

  jtm_sync #(.LINES(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({tdo, tdi, tms, tck}), .q_o(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) tck_d <= 1'b0;
    else     tck_d <= pins_s[0];
  end
  assign tck_rise = pins_s[0] && !tck_d;

  jtm_tracker u_trk (
    .clk(clk), .rst(rst), .edge_i(tck_rise), .tms_i(pins_s[1]),
    .cur_o(cur), .nxt_o(nxt), .prev_o(prev), .step_o(st_step)
  );

  jtm_scan_ctl #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst(rst), .edge_i(tck_rise), .cur_i(cur), .nxt_i(nxt),
    .wr_o(wr), .clr_o(clr), .cap_o(cap), .idx_o(idx),
    .rpt_valid(rpt_valid), .rpt_is_ir(rpt_is_ir), .rpt_len(rpt_len),
    .rpt_ovf(rpt_ovf)
  );

  assign lane_bit = pins_s[3:2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    jtm_lane #(.W(ACC_W), .IW(IW)) u_lane (
      .clk(clk), .rst(rst), .clr_i(clr), .wr_i(wr), .idx_i(idx),
      .bit_i(lane_bit[g]), .cap_i(cap), .word_o(lane_word[g])
    );
  end

  assign rpt_tdi = lane_word[0];
  assign rpt_tdo = lane_word[1];
  assign st_cur  = cur;
  assign st_prev = prev;
endmodule

// File: tb/jtag_scan_monitor_tb.sv
module jtag_scan_monitor_tb;
  localparam int W = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo = 1'b0;
  logic [3:0] st_cur, st_prev;
  logic st_step, rpt_valid, rpt_is_ir, rpt_ovf;
  logic [W-1:0] rpt_tdi, rpt_tdo;
  logic [15:0] rpt_len;

  always #10 clk = ~clk;

  jtag_scan_monitor u_dut (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .st_cur(st_cur), .st_prev(st_prev), .st_step(st_step),
    .rpt_valid(rpt_valid), .rpt_is_ir(rpt_is_ir), .rpt_tdi(rpt_tdi),
    .rpt_tdo(rpt_tdo), .rpt_len(rpt_len), .rpt_ovf(rpt_ovf)
  );

  typedef struct packed {
    logic ir; logic ovf; logic [15:0] len; logic [W-1:0] di; logic [W-1:0] dq;
  } rpt_t;

  logic [7:0] step_q [$];
  rpt_t       rpt_q  [$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0]   mst = 4'd1;
  logic [W-1:0] m_di = '0, m_dq = '0;
  int           m_len = 0;

  function automatic logic [3:0] nx(input logic [3:0] s, input logic m);
    case (s)
      0: return m ? 4'd0 : 4'd1;
      1: return m ? 4'd2 : 4'd1;
      2: return m ? 4'd9 : 4'd3;
      9: return m ? 4'd0 : 4'd10;
      3, 4: return m ? 4'd5 : 4'd4;
      5: return m ? 4'd8 : 4'd6;
      6: return m ? 4'd7 : 4'd6;
      7: return m ? 4'd8 : 4'd4;
      10, 11: return m ? 4'd12 : 4'd11;
      12: return m ? 4'd15 : 4'd13;
      13: return m ? 4'd14 : 4'd13;
      14: return m ? 4'd15 : 4'd11;
      default: return m ? 4'd2 : 4'd1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic di, input logic dq);
    logic [3:0] n;
    rpt_t r;
    @(negedge clk);
    tms = m; tdi = di; tdo = dq;
    repeat (3) @(negedge clk);
    n = nx(mst, m);
    step_q.push_back({mst, n});
    if (mst == 4'd4 || mst == 4'd11) begin
      if (m_len < W) begin m_di[m_len] = di; m_dq[m_len] = dq; end
      m_len++;
    end
    if (n == 4'd8 || n == 4'd15) begin
      r.ir = (n == 4'd15); r.ovf = (m_len > W); r.len = 16'(m_len);
      r.di = m_di; r.dq = m_dq;
      rpt_q.push_back(r);
    end
    if (n == 4'd8 || n == 4'd15 || n == 4'd3 || n == 4'd10) begin
      m_di = '0; m_dq = '0; m_len = 0;
    end
    mst = n;
    tck = 1'b1;
    repeat (4) @(negedge clk);
    tck = 1'b0;
  endtask

  // scan from idle; pz = bit index after which a pause detour is taken
  task automatic scan(input bit ir, input int n, input logic [127:0] di,
                      input logic [127:0] dq, input int pz);
    tick(1, 1, 1);
    if (ir) tick(1, 0, 0);
    tick(0, 1, 1);
    tick(0, 1, 0);
    for (int i = 0; i < n; i++) begin
      tick((i == n - 1) || (i == pz), di[i], dq[i]);
      if (i == pz && i != n - 1) begin
        tick(0, 1, 1); tick(0, 0, 1); tick(1, 1, 0); tick(0, 1, 1);
      end
    end
    tick(1, 1, 1);
    tick(0, 0, 0);
  endtask

  function automatic int plen(input int s);
    case (s)
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 4; 5: return 4;
      6: return 5; 7: return 6; 8: return 5; 9: return 3; 10: return 4; 11: return 5;
      12: return 5; 13: return 6; 14: return 7; default: return 6;
    endcase
  endfunction
  function automatic logic [7:0] pbits(input int s);
    case (s)
      2: return 8'b10; 3: return 8'b010; 4: return 8'b0010; 5: return 8'b1010;
      6: return 8'b01010; 7: return 8'b101010; 8: return 8'b11010; 9: return 8'b110;
      10: return 8'b0110; 11: return 8'b00110; 12: return 8'b10110;
      13: return 8'b010110; 14: return 8'b1010110; 15: return 8'b110110;
      default: return 8'b0;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (st_step) begin
        if (step_q.size() == 0) chk(0, "R5 unexpected step", {st_prev, st_cur}, 0);
        else begin
          logic [7:0] e;
          e = step_q.pop_front();
          if (e[7:4] inside {0, 1, 2, 9})
            chk({st_prev, st_cur} == e, "R3 transition", {st_prev, st_cur}, e);
          else
            chk({st_prev, st_cur} == e, "R4 transition", {st_prev, st_cur}, e);
        end
      end
      if (rpt_valid) begin
        if (rpt_q.size() == 0) chk(0, "R7 unexpected report", rpt_len, 0);
        else begin
          rpt_t r;
          r = rpt_q.pop_front();
          chk(rpt_tdi == r.di, "R6 tdi word", rpt_tdi, r.di);
          chk(rpt_tdo == r.dq, "R6 tdo word", rpt_tdo, r.dq);
          chk(rpt_is_ir == r.ir && rpt_len == r.len, "R7 type/len",
              {rpt_is_ir, rpt_len}, {r.ir, r.len});
          chk(rpt_ovf == r.ovf, "R8 overflow", rpt_ovf, r.ovf);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(st_cur == 4'd1 && !st_step && !rpt_valid, "R1 reset state",
        {st_cur, st_step, rpt_valid}, {4'd1, 2'b00});

    // R3 R4: every state, both mode-select values
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 5; k++) tick(1, 0, 0);
        for (int k = 0; k < plen(s); k++) tick(pbits(s)[k], 0, 0);
        chk(mst == 4'(s), "R3 walk reach", mst, s);
        tick(b[0], 1, 1);
      end
    end
    for (int k = 0; k < 5; k++) tick(1, 0, 0);
    tick(0, 0, 0);

    // R2: wires toggle while the test clock holds still
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); tms = k[0]; tdi = ~k[0]; tdo = k[1];
    end
    repeat (4) @(negedge clk);
    chk(st_cur == mst, "R2 no edge no change", st_cur, mst);

    // R6 R7: scans
    scan(1, 8, 128'hA5, 128'h3C, 3);
    scan(0, 32, 128'hDEADBEEF, 128'h12345678, -1);
    scan(0, 20, 128'h9A3C5, 128'h0F0F0, 9);
    scan(0, 1, 128'h1, 128'h0, -1);
    // R8: longer than the word
    scan(0, 70, {58'h0, 6'h2A, 64'h0123456789ABCDEF},
                {58'h0, 6'h15, 64'hFEDCBA9876543210}, 40);
    scan(1, 5, 128'h16, 128'h09, 2);

    repeat (10) @(negedge clk);
    chk(step_q.size() == 0, "R5 steps missing", step_q.size(), 0);
    chk(rpt_q.size() == 0, "R7 reports missing", rpt_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule